// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps a system through a clock rate switch between full, half and one-thirty-second speed. Software places a one-hot request code on the request input. When exactly one valid request bit goes from 0 to 1 while the block is idle, the sequencer pulls the active-low freeze line, waits as long as needed for the freeze acknowledge, then drives the active-low clock-change lines and the PLL bypass line on and off in a fixed order. Each wait between two steps comes from its own programmable cycle count.

All waits are counted in block clocks, which run at half the system frequency. A programmed count of N makes the matching step last N+1 block clocks, so a count of zero still takes one cycle. A separate switch-latency count starts when the change lines are released. When it runs out, the current-frequency output takes the new rate. The busy output stays high until both the settle wait and the latency wait have run out. Requests that arrive while the block is busy are dropped. Software is expected to clear the request code some time after setting it: about 16 system clocks, which is 8 block clocks.

Top module: `freq_change_seq`

## Requirements
- R1: After reset, freeze_n_o is 1, chg_n_o is all ones, pll_byp_o is 0, busy_o is 0, and freq_now_o is 0 (full rate).
- R2: Request encodings are 0x01 for full, 0x02 for half and 0x20 for 1/32. When the block is idle and one of these bits rises, with no other valid bit set, freeze_n_o goes to 0 and busy_o goes to 1 one cycle later.
- R3: Bits in the mask 0xDC are ignored. A code that has two or more valid bits set, or no valid bit set, starts nothing.
- R4: Freeze stays asserted until freeze_ack_i is high at a clock edge. If the acknowledge is first sampled D cycles after freeze falls, chg_n_o goes to all zeros D+A+2 cycles after freeze falls, where A is the change-on count.
- R5: pll_byp_o rises B+1 cycles after the change lines assert, where B is the bypass-on count.
- R6: pll_byp_o falls DB+1 cycles after it rose. The change lines return to all ones DC+1 cycles after bypass falls. Bypass is only ever high while the change lines are asserted.
- R7: freeze_n_o returns to 1 P+1 cycles after the change lines release, where P is the settle count.
- R8: freq_now_o takes the requested rate (0 full, 1 half, 2 for 1/32) F+1 cycles after the change lines release, where F is the latency count. It does not move while the change lines are asserted.
- R9: busy_o is high from the start until max(P,F)+1 cycles after the change lines release.
- R10: A request that rises while busy_o is high is ignored. A code still held after the block goes idle does not start a new sequence.
- R11: All change lines switch together.
- R12: A count of zero gives a one-cycle step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (half system rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_code_i | input | 8 | Software request code |
| t_chg_on_i | input | 8 | Wait from acknowledge to change assert |
| t_byp_on_i | input | 16 | Wait from change assert to bypass assert |
| t_byp_off_i | input | 8 | Bypass high time |
| t_chg_off_i | input | 8 | Wait from bypass drop to change release |
| t_settle_i | input | 32 | Wait from change release to freeze release |
| t_latency_i | input | 32 | Wait from change release to new-rate indication |
| freeze_ack_i | input | 1 | Freeze acknowledge from the system |
| freeze_n_o | output | 1 | Active-low freeze |
| chg_n_o | output | 3 | Active-low clock-change lines |
| pll_byp_o | output | 1 | PLL bypass |
| freq_now_o | output | 2 | Current rate: 0 full, 1 half, 2 for 1/32 |
| busy_o | output | 1 | Sequence or latency wait in progress |

## Verification
The assertions assume that the timing counts stay constant while a sequence runs, and that freeze_ack_i is raised only after freeze has been asserted. The bench sets every count and the request code on a falling edge before it raises the request. It raises the acknowledge a chosen number of cycles after it sees freeze fall, and lowers it only after busy drops. Each run asks for a rate different from the current one, so the rate change can be seen at the output.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRZ,
    ST_ACHG,
    ST_ABYP,
    ST_DBYP,
    ST_DCHG,
    ST_SETL
  } seq_state_e;

  typedef enum logic [1:0] {
    FRQ_FULL = 2'd0,
    FRQ_HALF = 2'd1,
    FRQ_SLOW = 2'd2
  } freq_e;

  localparam int REQ_W = 8;
  localparam logic [REQ_W-1:0] REQ_FULL  = 8'h01;
  localparam logic [REQ_W-1:0] REQ_HALF  = 8'h02;
  localparam logic [REQ_W-1:0] REQ_SLOW  = 8'h20;
  localparam logic [REQ_W-1:0] REQ_VALID = REQ_FULL | REQ_HALF | REQ_SLOW;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         active_o,
  output logic         expire_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load_i) begin
      cnt_d = val_i;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
  assign expire_o = act_q && (cnt_q == '0);

endmodule

// File: rtl/fcs_req_detect.sv
module fcs_req_detect
  import fcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_W-1:0] code_i,
  input  logic             armed_i,
  output logic             start_o,
  output freq_e            tgt_o
);

  logic [REQ_W-1:0] prev_q;
  logic [REQ_W-1:0] live;
  logic [REQ_W-1:0] rise;
  logic             single;

  function automatic logic is_single(logic [REQ_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < REQ_W; i++) n += int'(v[i]);
    return (n == 1);
  endfunction

  assign live    = code_i & REQ_VALID;
  assign rise    = live & ~prev_q;
  assign single  = is_single(live);
  assign start_o = armed_i && single && (rise != '0);

  always_comb begin
    tgt_o = FRQ_FULL;
    if (live == REQ_HALF)      tgt_o = FRQ_HALF;
    else if (live == REQ_SLOW) tgt_o = FRQ_SLOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= live;
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R10

endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
  import fcs_pkg::*;
#(
  parameter int ACT_W  = 8,
  parameter int ABT_W  = 16,
  parameter int DABT_W = 8,
  parameter int DACT_W = 8,
  parameter int PST_W  = 32,
  parameter int FSL_W  = 32,
  parameter int CHG_N  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REQ_W-1:0]  req_code_i,
  input  logic [ACT_W-1:0]  t_chg_on_i,
  input  logic [ABT_W-1:0]  t_byp_on_i,
  input  logic [DABT_W-1:0] t_byp_off_i,
  input  logic [DACT_W-1:0] t_chg_off_i,
  input  logic [PST_W-1:0]  t_settle_i,
  input  logic [FSL_W-1:0]  t_latency_i,
  input  logic              freeze_ack_i,
  output logic              freeze_n_o,
  output logic [CHG_N-1:0]  chg_n_o,
  output logic              pll_byp_o,
  output logic [1:0]        freq_now_o,
  output logic              busy_o
);

  localparam int MAIN_W = max2(max2(max2(ACT_W, ABT_W), max2(DABT_W, DACT_W)), PST_W);

  logic              rst_n;
  seq_state_e        st_q, st_d;
  freq_e             tgt_q, tgt_d, req_tgt;
  freq_e             freq_q, freq_d;
  logic              start, armed, tgt_en;
  logic              ld, main_act, main_exp;
  logic [MAIN_W-1:0] ld_val;
  logic              lat_ld, lat_act, lat_exp;
  logic              chg_act;

  fcs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign armed = (st_q == ST_IDLE) && !lat_act;

  fcs_req_detect i_req_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .code_i  (req_code_i),
    .armed_i (armed),
    .start_o (start),
    .tgt_o   (req_tgt)
  );

  fcs_timer #(.W(MAIN_W)) i_step_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (ld),
    .val_i    (ld_val),
    .active_o (main_act),
    .expire_o (main_exp)
  );

  fcs_timer #(.W(FSL_W)) i_lat_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (lat_ld),
    .val_i    (t_latency_i),
    .active_o (lat_act),
    .expire_o (lat_exp)
  );

  // step sequencing
  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    lat_ld = 1'b0;
    tgt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_FRZ;
        tgt_en = 1'b1;
      end
      ST_FRZ: if (freeze_ack_i) begin
        st_d   = ST_ACHG;
        ld     = 1'b1;
        ld_val = MAIN_W'(t_chg_on_i);
      end
      ST_ACHG: if (main_exp) begin
        st_d   = ST_ABYP;
        ld     = 1'b1;
        ld_val = MAIN_W'(t_byp_on_i);
      end
      ST_ABYP: if (main_exp) begin
        st_d   = ST_DBYP;
        ld     = 1'b1;
        ld_val = MAIN_W'(t_byp_off_i);
      end
      ST_DBYP: if (main_exp) begin
        st_d   = ST_DCHG;
        ld     = 1'b1;
        ld_val = MAIN_W'(t_chg_off_i);
      end
      ST_DCHG: if (main_exp) begin
        st_d   = ST_SETL;
        ld     = 1'b1;
        ld_val = MAIN_W'(t_settle_i);
        lat_ld = 1'b1;
      end
      ST_SETL: if (main_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tgt_d  = tgt_en  ? req_tgt : tgt_q;
    freq_d = lat_exp ? tgt_q   : freq_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= FRQ_FULL;
      freq_q <= FRQ_FULL;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      freq_q <= freq_d;
    end
  end

  assign chg_act    = (st_q == ST_ABYP) || (st_q == ST_DBYP) || (st_q == ST_DCHG);
  assign freeze_n_o = (st_q == ST_IDLE);
  assign chg_n_o    = {CHG_N{~chg_act}};
  assign pll_byp_o  = (st_q == ST_DBYP);
  assign freq_now_o = freq_q;
  assign busy_o     = (st_q != ST_IDLE) || lat_act;

  AST_FRZ_WAITS_ACK: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_FRZ && !freeze_ack_i) |=> (st_q == ST_FRZ)); // R4
  AST_CHG_IN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chg_n_o != {CHG_N{1'b1}}) |-> !freeze_n_o); // R4
  AST_BYP_IN_CHG: assert property (@(posedge clk_i) disable iff (!rst_n)
    pll_byp_o |-> (chg_n_o == '0)); // R6
  AST_CHG_LINES_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chg_n_o == '0) || (chg_n_o == {CHG_N{1'b1}})); // R11
  AST_FREEZE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !freeze_n_o |-> busy_o); // R9
  AST_FREQ_STEADY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chg_n_o == '0) |-> $stable(freq_now_o)); // R8
  AST_STEP_TIMED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q inside {ST_ACHG, ST_ABYP, ST_DBYP, ST_DCHG, ST_SETL}) |-> main_act); // R12

endmodule

// File: tb/test_freq_change_seq.sv
module test_freq_change_seq;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic [7:0]  req;
  logic [7:0]  t_a, t_db, t_dc;
  logic [15:0] t_b;
  logic [31:0] t_p, t_f;
  logic        frz_ack;
  logic        freeze_n, pll_byp, busy;
  logic [2:0]  chg_n;
  logic [1:0]  freq_now;

  int total = 0;
  int bad   = 0;

  freq_change_seq i_freq_change_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_code_i   (req),
    .t_chg_on_i   (t_a),
    .t_byp_on_i   (t_b),
    .t_byp_off_i  (t_db),
    .t_chg_off_i  (t_dc),
    .t_settle_i   (t_p),
    .t_latency_i  (t_f),
    .freeze_ack_i (frz_ack),
    .freeze_n_o   (freeze_n),
    .chg_n_o      (chg_n),
    .pll_byp_o    (pll_byp),
    .freq_now_o   (freq_now),
    .busy_o       (busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_switch(logic [7:0] code, logic [7:0] later,
                            int a, int b, int db, int dc, int p, int f, int d,
                            int exp_freq);
    int tf = -1, tcf = -1, tbr = -1, tbf = -1, tcr = -1, tfr = -1, tq = -1, tbz = -1;
    int t = 0;
    int lng;
    logic [1:0] f0;
    @(negedge clk);
    t_a = 8'(a); t_b = 16'(b); t_db = 8'(db); t_dc = 8'(dc);
    t_p = 32'(p); t_f = 32'(f);
    frz_ack = 1'b0;
    f0 = freq_now;
    req = code;
    while (t < 4000 && tbz < 0) begin
      @(negedge clk);
      t++;
      if (tf < 0 && !freeze_n) tf = t;
      if (tcf < 0 && chg_n == 3'b000) tcf = t;
      if (tbr < 0 && pll_byp) tbr = t;
      if (tbr >= 0 && tbf < 0 && !pll_byp) tbf = t;
      if (tcf >= 0 && tcr < 0 && chg_n == 3'b111) tcr = t;
      if (tf >= 0 && tfr < 0 && freeze_n) tfr = t;
      if (tq < 0 && freq_now != f0) tq = t;
      if (tf >= 0 && tbz < 0 && !busy) tbz = t;
      if (t == 1) chk(busy == 1'b1, "R2 busy high after start", busy, 1);
      if (tf >= 0 && t == tf + d) frz_ack = 1'b1;
      if (t == 8) req = later;
    end
    frz_ack = 1'b0;
    lng = (p > f) ? p : f;
    chk(tf == 1, "R2 freeze one cycle after request", tf, 1);
    chk(tcf - tf == d + a + 2, "R4 freeze to change assert", tcf - tf, d + a + 2);
    chk(tbr - tcf == b + 1, "R5 change to bypass assert", tbr - tcf, b + 1);
    chk(tbf - tbr == db + 1, "R6 bypass width", tbf - tbr, db + 1);
    chk(tcr - tbf == dc + 1, "R6 bypass drop to change release", tcr - tbf, dc + 1);
    chk(tfr - tcr == p + 1, "R7 change release to freeze release", tfr - tcr, p + 1);
    chk(tq - tcr == f + 1, "R8 change release to new rate", tq - tcr, f + 1);
    chk(freq_now == 2'(exp_freq), "R8 rate code", freq_now, exp_freq);
    chk(tbz - tcr == lng + 1, "R9 busy end", tbz - tcr, lng + 1);
  endtask

  task automatic expect_idle(string tag, logic [7:0] code, int cycles);
    logic [1:0] f0;
    bit seen = 0;
    @(negedge clk);
    f0 = freq_now;
    req = code;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!freeze_n || busy || chg_n != 3'b111) seen = 1;
    end
    chk(!seen, tag, seen, 0);
    chk(freq_now == f0, tag, freq_now, f0);
  endtask

  task automatic clear_req();
    @(negedge clk);
    req = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(freeze_n == 1'b1, "R1 freeze idle", freeze_n, 1);
    chk(chg_n == 3'b111, "R1 change idle", chg_n, 7);
    chk(pll_byp == 1'b0, "R1 bypass idle", pll_byp, 0);
    chk(busy == 1'b0, "R1 not busy", busy, 0);
    chk(freq_now == 2'd0, "R1 full rate", freq_now, 0);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; frz_ack = 1'b0;
    t_a = '0; t_b = '0; t_db = '0; t_dc = '0; t_p = '0; t_f = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    // full to half, late acknowledge
    run_switch(8'h02, 8'h00, 3, 5, 2, 4, 6, 2, 3, 1);
    clear_req();
    // half to 1/32, all zero step counts (R12), latency longer than settle
    run_switch(8'h20, 8'h00, 0, 0, 0, 0, 1, 9, 0, 2);
    clear_req();
    // R3: invalid codes start nothing
    expect_idle("R3 two valid bits", 8'h22, 12);
    clear_req();
    expect_idle("R3 reserved bits only", 8'hDC, 12);
    clear_req();
    expect_idle("R3 three valid bits", 8'h23, 12);
    clear_req();
    // R3: reserved bit beside a valid bit is ignored, back to full
    run_switch(8'h81, 8'h00, 1, 2, 3, 1, 4, 4, 1, 0);
    clear_req();
    // R10: request rising while busy ignored, then held code does not restart
    run_switch(8'h02, 8'h20, 2, 1, 1, 2, 3, 1, 5, 1);
    expect_idle("R10 held request after idle", 8'h20, 12);
    chk(freq_now == 2'd1, "R10 rate kept", freq_now, 1);
    clear_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule